// File: doc/BRIEF.md
# Programmable Watchdog Timer with Reset/Interrupt Steering

This block is a watchdog timer that counts slow time ticks, one tick being a sixteenth of a second. Software arms it with a single control byte. That byte holds three fields: a 5-bit multiplier, a 2-bit resolution that scales the multiplier by a power of four, and a steering bit. Writing the control byte restarts the countdown from the new setting. Reading it back also counts as a service ("kick") and restarts the countdown from the setting already held.

When the countdown runs out, the block latches an expiry flag in a read-only flags register. The steering bit then chooses one of two actions. With the bit set, the block raises a one-cycle system reset request, wipes the control byte and clears a marker bit in a companion mark register. With the bit clear, it raises a one-cycle interrupt pulse and stops counting until the next kick. Driving the actual reset, the time-of-day clock and the alarm is left to neighbouring logic.

Top module: `wdt_steer`

## Requirements
- R1: After synchronous reset, the flags (address 0), control (address 1) and mark (address 2) registers read 0x00, and `rst_req` and `irq` are low. Address 3 always reads 0x00.
- R2: Control byte encoding: bit 7 is the steering bit, bits 6:2 are the multiplier M, bits 1:0 are the resolution R. After a control write, the expiry pulse appears after the edge that samples the (M << 2R)-th `tick`, and not before that tick.
- R3: If the multiplier field is zero (this includes a control value of 0x00), the timer never expires, whatever the ticks.
- R4: A write to the control register clears flags bit 7 and restarts the countdown from the newly written value.
- R5: A read of the control register clears flags bit 7 and restarts the countdown from the value currently held.
- R6: On expiry, flags bit 7 is set. It stays set until the next control access or reset. Flags bits 6:0 always read 0.
- R7: If control bit 7 is set at expiry, `rst_req` pulses high for exactly one cycle, the control register becomes 0x00, and only bit 6 of the mark register is cleared.
- R8: If control bit 7 is clear at expiry, `irq` pulses high for exactly one cycle and the control register keeps its value. No further expiry occurs until the next kick.
- R9: Writes to the flags register have no effect.
- R10: A control access in the same cycle as the tick that would expire the count takes priority: no expiry occurs, and the countdown restarts.
- R11: `rst_req` and `irq` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register select: 0 flags, 1 control, 2 mark, 3 reads zero |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Read data for `addr`, combinational |
| tick | input | 1 | One-cycle pulse each sixteenth of a second |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | One-cycle interrupt pulse |
| flags | output | 8 | Flags register value; bit 7 is the expiry flag |

## Verification
The bound checker watches, on every cycle, the properties that relate the outputs to one another and to recent inputs:
- the two pulses are mutually exclusive and each lasts one cycle;
- every pulse follows a tick;
- the expiry flag rises only together with a pulse and falls only after a control access;
- a reset request always comes with an empty control register.

The exact tick count for each multiplier and resolution cannot be seen by a property. The same holds for these behaviours, which only the bench's scenarios show:
- an interrupt-mode expiry stays silent afterwards;
- a mid-count write or read restarts the count;
- a kick that coincides with the final tick wins;
- the mark register loses only its marker bit.

// File: rtl/wdt_pkg.sv
// wdt_pkg: shared field positions and register selects for the watchdog.
// Assumes an 8-bit register data path and a 2-bit register select.
package wdt_pkg;
    localparam int DATA_W    = 8;
    localparam int RES_LSB   = 0;
    localparam int MULT_LSB  = 2;
    localparam int STEER_BIT = 7;
    localparam int MARK_BIT  = 6;
    localparam int FLAG_BIT  = 7;

    typedef enum logic [1:0] {
        REG_FLAGS = 2'd0,
        REG_CTRL  = 2'd1,
        REG_MARK  = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/wdt_period.sv
// wdt_period: turns multiplier and resolution fields into a tick count,
// multiplier * 4^resolution. Purely combinational.
// Assumes CNT_W is wide enough for the largest product.
module wdt_period #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2,
    parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
    input  logic [MULT_W-1:0] mult,
    input  logic [RES_W-1:0]  res,
    output logic [CNT_W-1:0]  period
);
    localparam int NRES = 1 << RES_W;

    logic [CNT_W-1:0] cand [NRES];
    logic [CNT_W-1:0] mult_ext;

    assign mult_ext = {{(CNT_W - MULT_W){1'b0}}, mult};

    // One pre-shifted candidate per resolution step.
    for (genvar g = 0; g < NRES; g++) begin : g_res
        assign cand[g] = mult_ext << (2 * g);
    end

    // The resolution field picks the candidate.
    assign period = cand[res];
endmodule

// File: rtl/wdt_count.sv
// wdt_count: down counter in tick units. A load restarts it; a zero load
// parks it. It raises 'expire' for the cycle whose tick ends the count,
// unless a load arrives in that same cycle, and it stops after expiring.
// Assumes 'tick' is a single-cycle pulse.
module wdt_count #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] remain_q;
    logic             run_q;

    // Expiry: last remaining tick while running, with no reload competing.
    assign expire = run_q && tick && (remain_q == CNT_W'(1)) && !load;

    // Countdown state: reload, decrement per tick, park on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            run_q    <= 1'b0;
        end else if (load) begin
            remain_q <= load_val;
            run_q    <= (load_val != '0);
        end else if (run_q && tick) begin
            if (remain_q == CNT_W'(1)) begin
                remain_q <= '0;
                run_q    <= 1'b0;
            end else begin
                remain_q <= remain_q - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/wdt_regs.sv
// wdt_regs: control, mark and flags registers, the read mux, kick
// detection and the steered output pulses.
// Assumes at most one of wr_en / rd_en per cycle; 'expire' already loses
// to a kick in the counter.
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              expire,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              flag_q,
    output logic              kick_wr,
    output logic              kick_rd,
    output logic              rst_req,
    output logic              irq
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] mark_q;
    logic              steer;
    logic              exp_rst;
    logic              exp_int;

    assign sel     = reg_sel_e'(addr);
    assign kick_wr = wr_en && (sel == REG_CTRL);
    assign kick_rd = rd_en && (sel == REG_CTRL);
    assign steer   = ctrl_q[STEER_BIT];
    assign exp_rst = expire && steer;
    assign exp_int = expire && !steer;

    // Control byte: loaded by writes, wiped by a reset-steered expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (kick_wr) ctrl_q <= wdata;
        else if (exp_rst) ctrl_q <= '0;
    end

    // Mark register: software-written, marker bit dropped on watchdog reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                        mark_q <= '0;
        else if (wr_en && sel == REG_MARK) mark_q <= wdata;
        else if (exp_rst)                  mark_q[MARK_BIT] <= 1'b0;
    end

    // Expiry flag: set by expiry, cleared by any control access.
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag_q <= 1'b0;
        else if (kick_wr || kick_rd) flag_q <= 1'b0;
        else if (expire)             flag_q <= 1'b1;
    end

    // Steered single-cycle outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
            irq     <= 1'b0;
        end else begin
            rst_req <= exp_rst;
            irq     <= exp_int;
        end
    end

    // Read mux; the flags register exposes only its top bit.
    always_comb begin
        rdata = '0;
        case (sel)
            REG_FLAGS: rdata[FLAG_BIT] = flag_q;
            REG_CTRL:  rdata = ctrl_q;
            REG_MARK:  rdata = mark_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_steer.sv
// wdt_steer: top of the watchdog. It decodes the reload value from either
// the incoming write (write kick) or the held control byte (read kick),
// runs the countdown, and exposes registers and steered pulses.
// Assumes 'tick' is synchronous to clk and one cycle wide.
module wdt_steer
    import wdt_pkg::*;
#(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick,
    output logic              rst_req,
    output logic              irq,
    output logic [DATA_W-1:0] flags
);
    localparam int CNT_W = MULT_W + 2 * ((1 << RES_W) - 1);

    logic [DATA_W-1:0] ctrl_q;
    logic              flag_q;
    logic              kick_wr;
    logic              kick_rd;
    logic              expire;
    logic [CNT_W-1:0]  per_wr;
    logic [CNT_W-1:0]  per_held;
    logic [CNT_W-1:0]  load_val;

    wdt_period #(.MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_per_wr (
        .mult   (wdata[MULT_LSB +: MULT_W]),
        .res    (wdata[RES_LSB +: RES_W]),
        .period (per_wr)
    );

    wdt_period #(.MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_per_held (
        .mult   (ctrl_q[MULT_LSB +: MULT_W]),
        .res    (ctrl_q[RES_LSB +: RES_W]),
        .period (per_held)
    );

    // Reload source: the new byte on a write, the held byte on a read.
    assign load_val = kick_wr ? per_wr : per_held;

    wdt_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (kick_wr || kick_rd),
        .load_val (load_val),
        .tick     (tick),
        .expire   (expire)
    );

    wdt_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wdata   (wdata),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .expire  (expire),
        .rdata   (rdata),
        .ctrl_q  (ctrl_q),
        .flag_q  (flag_q),
        .kick_wr (kick_wr),
        .kick_rd (kick_rd),
        .rst_req (rst_req),
        .irq     (irq)
    );

    assign flags = {flag_q, {(DATA_W - 1){1'b0}}};
endmodule

// File: rtl/wdt_steer_chk.sv
// wdt_steer_chk: cycle-by-cycle properties of the watchdog top, bound
// into every wdt_steer instance. Assumes synchronous active-low reset.
module wdt_steer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic       tick,
    input logic       rst_req,
    input logic       irq,
    input logic [7:0] flags,
    input logic [7:0] ctrl_q
);
    logic ctrl_access;
    assign ctrl_access = (wr_en || rd_en) && (addr == 2'd1);

    assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && irq));

    assert_rst_wipes_ctrl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (ctrl_q == 8'h00));

    assert_rst_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_pulse_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || irq) |-> $past(tick));

    assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[7]) |-> (rst_req || irq));

    assert_flag_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flags[6:0] == 7'd0);

    // R4 and R5: the flag only drops after a control access.
    assert_flag_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[7]) |-> $past(ctrl_access));
endmodule

bind wdt_steer wdt_steer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .tick    (tick),
    .rst_req (rst_req),
    .irq     (irq),
    .flags   (flags),
    .ctrl_q  (ctrl_q)
);

// File: tb/wdt_steer_test.sv
`timescale 1ns/1ps
// wdt_steer_test: sweeps every resolution and a wide range of multipliers
// (expected timeout computed as M << 2R), plus directed kick, priority
// and write-protection scenarios.
module wdt_steer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] rdata;
    logic       rst_req;
    logic       irq;
    logic [7:0] flags;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    wdt_steer uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .tick(tick),
        .rst_req(rst_req), .irq(irq), .flags(flags)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic do_tick(output bit si, output bit sr);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        si = irq; sr = rst_req;
    endtask

    // Issue n ticks; return the number of ticks that produced a pulse.
    task automatic ticks_pulses(input int n, output int cnt);
        bit si, sr;
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            do_tick(si, sr);
            if (si || sr) cnt++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int cnt;
        bit si, sr;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 rst_req", rst_req, 0);
        chk("R1 irq", irq, 0);
        bus_rd(2'd0, d); chk("R1 flags", d, 0);
        bus_rd(2'd2, d); chk("R1 mark", d, 0);
        bus_rd(2'd3, d); chk("R1 addr3", d, 0);
        bus_rd(2'd1, d); chk("R1 ctrl", d, 0);
        ticks_pulses(10, cnt); chk("R1 idle no pulse", cnt, 0);

        // R3: zero multiplier never expires
        bus_wr(2'd1, 8'h00); ticks_pulses(40, cnt); chk("R3 ctrl 0x00", cnt, 0);
        bus_wr(2'd1, 8'h83); ticks_pulses(40, cnt); chk("R3 mult0 res3", cnt, 0);
        bus_rd(2'd0, d); chk("R3 flag", d, 0);

        // R2, R6, R7, R8: sweep resolutions and multipliers
        for (int r = 0; r < 4; r++) begin
            for (int m = 1; m < 32; m++) begin
                logic [7:0] val;
                bit steer;
                int n, hit;
                bit kr;
                if (r == 3 && m > 4) continue;
                steer = m[0];
                n = m << (2 * r);
                val = {steer, m[4:0], r[1:0]};
                bus_wr(2'd2, 8'hFF);
                bus_wr(2'd1, val);
                hit = 0; kr = 1'b0;
                for (int k = 1; k <= n + 2; k++) begin
                    do_tick(si, sr);
                    if (si || sr) begin hit = k; kr = sr; break; end
                end
                chk("R2 expiry tick", hit, n);
                chk(steer ? "R7 rst_req kind" : "R8 irq kind", kr, steer);
                @(negedge clk);
                chk(steer ? "R7 single cycle" : "R8 single cycle", irq | rst_req, 0);
                bus_rd(2'd0, d); chk("R6 flag set", d, 8'h80);
                bus_rd(2'd2, d); chk("R7 mark", d, steer ? 8'hBF : 8'hFF);
                bus_rd(2'd1, d); chk(steer ? "R7 ctrl wiped" : "R8 ctrl kept", d, steer ? 0 : val);
                bus_rd(2'd0, d); chk("R5 read clears flag", d, 0);
            end
        end

        // R8: interrupt mode stays silent after expiry until a kick
        bus_wr(2'd1, 8'h08);
        ticks_pulses(2, cnt); chk("R8 first expiry", cnt, 1);
        ticks_pulses(30, cnt); chk("R8 stopped", cnt, 0);
        bus_rd(2'd0, d); chk("R6 flag held", d, 8'h80);

        // R9: flags not writable
        bus_wr(2'd0, 8'h00); bus_rd(2'd0, d); chk("R9 write 0 ignored", d, 8'h80);
        // R4: control write clears flag
        bus_wr(2'd1, 8'h00); bus_rd(2'd0, d); chk("R4 write clears flag", d, 0);
        bus_wr(2'd0, 8'hFF); bus_rd(2'd0, d); chk("R9 write FF ignored", d, 0);

        // R4: mid-count write restarts from new value
        bus_wr(2'd1, 8'h14);
        ticks_pulses(3, cnt); chk("R4 before rewrite", cnt, 0);
        bus_wr(2'd1, 8'h0C);
        ticks_pulses(2, cnt); chk("R4 not early", cnt, 0);
        ticks_pulses(1, cnt); chk("R4 restart expiry", cnt, 1);

        // R5: mid-count read restarts with held value (5 ticks)
        bus_wr(2'd1, 8'h14);
        ticks_pulses(3, cnt);
        bus_rd(2'd1, d); chk("R5 ctrl value", d, 8'h14);
        ticks_pulses(4, cnt); chk("R5 not early", cnt, 0);
        ticks_pulses(1, cnt); chk("R5 restart expiry", cnt, 1);

        // R10: kick on the final tick wins
        bus_wr(2'd1, 8'h08);
        ticks_pulses(1, cnt);
        @(negedge clk); tick = 1'b1; addr = 2'd1; wdata = 8'h08; wr_en = 1'b1;
        @(negedge clk); tick = 1'b0; wr_en = 1'b0;
        chk("R10 no pulse", irq | rst_req, 0);
        bus_rd(2'd0, d); chk("R10 no flag", d, 0);
        ticks_pulses(1, cnt); chk("R10 restarted not early", cnt, 0);
        ticks_pulses(1, cnt); chk("R10 restarted expiry", cnt, 1);

        // R11: reset-mode expiry raises only rst_req
        bus_wr(2'd1, 8'h84);
        do_tick(si, sr);
        chk("R11 irq low", si, 0);
        chk("R11 rst_req high", sr, 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule